// File: doc/BRIEF.md
# Memory Controller Error Capture Unit

This unit records faults reported by a memory controller and raises an interrupt for them. Three fault sources each deliver a one-cycle pulse: address decode failures, accesses to an invalid translation-table page, and security violations. Each pulse comes with the requesting client's ID, a write flag and the faulting address. A security violation also carries a subtype flag.

Each fault source has its own pair of registers. The first holds a status word whose layout depends on the fault type. The second holds the faulting address and sits one word (4 bytes) above the first. Each source also has one bit in a shared pending register. Software clears a pending bit by writing a one to it. A mask register selects which pending bits drive the interrupt line. While a bit is pending, its captured record is frozen, so software always reads the first fault of that type.

Register map (byte offsets on `reg_addr`): 0x00 pending register (write one to clear), 0x04 interrupt mask, 0x10/0x14 decode status/address, 0x18/0x1C translation status/address, 0x20/0x24 security status/address. Other offsets read as zero.

Top module: `memerr_capture`

## Requirements
- R1: The decode-fault status word has the client ID in bits [CID_W-1:0] and bit 31 set for a write. All other bits are zero.
- R2: The translation-fault status word has the write flag in bit 0 and the client ID in bits [CID_W:1]. All other bits are zero.
- R3: The security-fault status word has the client ID in bits [CID_W-1:0], the subtype flag in bit 30 and the write flag in bit 31. All other bits are zero.
- R4: The captured faulting address of each type reads at that type's status offset plus 4.
- R5: The pending register has bit 0 for decode, bit 1 for translation and bit 2 for security faults. Several bits can be set at once.
- R6: Writing to the pending register clears every bit written as one and leaves bits written as zero unchanged.
- R7: While a type's pending bit is set, further faults of that type change neither its status word nor its address.
- R8: If a fault arrives in the same cycle that software clears that type's bit, the new fault is captured and the bit stays set.
- R9: The mask register at 0x04 reads back what was last written to it. `irq` goes high one cycle after a pending bit is set while its mask bit is set.
- R10: After reset, the pending register, the mask, every status word and every address read zero, and `irq` is low.
- R11: `irq` stays low while only masked-off bits are pending, and drops one cycle after the last enabled pending bit clears or is masked off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_vld | input | 1 | Decode fault pulse |
| dec_client | input | CID_W | Decode fault client ID |
| dec_write | input | 1 | Decode fault was a write |
| dec_addr | input | ERR_AW | Decode fault address |
| xlt_vld | input | 1 | Translation fault pulse |
| xlt_client | input | CID_W | Translation fault client ID |
| xlt_write | input | 1 | Translation fault was a write |
| xlt_addr | input | ERR_AW | Translation fault address |
| sec_vld | input | 1 | Security fault pulse |
| sec_client | input | CID_W | Security fault client ID |
| sec_write | input | 1 | Security fault was a write |
| sec_subtype | input | 1 | Security fault subtype flag |
| sec_addr | input | ERR_AW | Security fault address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Registered interrupt level |

## Verification
A fault pulse and a software clear of the same type's pending bit can fall in the same clock cycle. The bench provokes this by asserting the decode pulse and a one-to-clear write of bit 0 in one cycle while an earlier decode record is held. It then judges through the register interface that bit 0 is still pending and that the status and address registers hold the newer fault, not the older one. A second overlap, a fault arriving while its bit is still pending, is judged by reading back an unchanged record.

// File: rtl/memerr_pkg.sv
// Package: shared constants and types for the memory error capture unit.
// Assumes byte-addressed 32-bit registers decoded on an 8-bit offset.
package memerr_pkg;
    localparam int NT     = 3;   // number of fault types
    localparam int REG_AW = 8;   // register offset width
    localparam int REG_DW = 32;  // register data width

    typedef enum logic [1:0] {
        KIND_DEC = 2'd0,
        KIND_XLT = 2'd1,
        KIND_SEC = 2'd2
    } err_kind_e;

    localparam logic [REG_AW-1:0] OFS_PEND = 8'h00;
    localparam logic [REG_AW-1:0] OFS_MASK = 8'h04;
    localparam logic [REG_AW-1:0] OFS_REC0 = 8'h10;

    // Byte offset of the status register of fault type k; the address follows at +4.
    function automatic logic [REG_AW-1:0] rec_base(input int k);
        return OFS_REC0 + REG_AW'(8 * k);
    endfunction
endpackage

// File: rtl/memerr_slot.sv
// Module: one fault-type record: pending flag, status word and faulting address.
// The status layout is picked by KIND. Assumes err_vld is a single-cycle pulse
// and clr is the decoded one-to-clear bit for this type.
module memerr_slot
    import memerr_pkg::*;
#(
    parameter err_kind_e KIND   = KIND_DEC,
    parameter int        CID_W  = 6,
    parameter int        ERR_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_vld,
    input  logic [CID_W-1:0]  err_cid,
    input  logic              err_wr,
    input  logic              err_aux,
    input  logic [ERR_AW-1:0] err_addr,
    input  logic              clr,
    output logic              pending,
    output logic [REG_DW-1:0] stat_q,
    output logic [ERR_AW-1:0] addr_q
);
    logic [REG_DW-1:0] word;
    logic              take;

    // Format the status word for this fault type.
    generate
        if (KIND == KIND_XLT) begin : g_xlt
            logic unused_aux;
            assign unused_aux = err_aux;
            always_comb begin
                word = '0;
                word[0] = err_wr;
                word[CID_W:1] = err_cid;
            end
        end else if (KIND == KIND_SEC) begin : g_sec
            always_comb begin
                word = '0;
                word[CID_W-1:0] = err_cid;
                word[30] = err_aux;
                word[31] = err_wr;
            end
        end else begin : g_dec
            logic unused_aux;
            assign unused_aux = err_aux;
            always_comb begin
                word = '0;
                word[CID_W-1:0] = err_cid;
                word[31] = err_wr;
            end
        end
    endgenerate

    // A fault is taken when nothing is held or the held record is being cleared.
    assign take = err_vld && (!pending || clr);

    // Capture the record, hold it while pending, drop the flag on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            stat_q  <= '0;
            addr_q  <= '0;
        end else if (take) begin
            pending <= 1'b1;
            stat_q  <= word;
            addr_q  <= err_addr;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    // R7
    hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> ($stable(stat_q) && $stable(addr_q) && pending));

    // R8
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && clr) |=> (pending && addr_q == $past(err_addr)));

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !err_vld) |=> !pending);

    // R4
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !pending) |=> (pending && addr_q == $past(err_addr)));
endmodule

// File: rtl/memerr_irq.sv
// Module: interrupt mask register and registered interrupt level.
// Assumes pend comes from the per-type records and mask_we is a decoded write.
module memerr_irq
    import memerr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic [NT-1:0] mask_wdata,
    input  logic [NT-1:0] pend,
    output logic [NT-1:0] mask_q,
    output logic          irq
);
    // Load the mask from software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Register the OR of the enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & mask_q);
    end

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & mask_q)) |=> irq);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & mask_q)) |=> !irq);
endmodule

// File: rtl/memerr_capture.sv
// Module: top of the memory error capture unit. Packs the three fault sources,
// instantiates one record per type, decodes register writes and muxes reads.
// Assumes CID_W <= 30 so the security flags in bits 30/31 stay clear of the ID.
module memerr_capture
    import memerr_pkg::*;
#(
    parameter int CID_W  = 6,
    parameter int ERR_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic [CID_W-1:0]  dec_client,
    input  logic              dec_write,
    input  logic [ERR_AW-1:0] dec_addr,
    input  logic              xlt_vld,
    input  logic [CID_W-1:0]  xlt_client,
    input  logic              xlt_write,
    input  logic [ERR_AW-1:0] xlt_addr,
    input  logic              sec_vld,
    input  logic [CID_W-1:0]  sec_client,
    input  logic              sec_write,
    input  logic              sec_subtype,
    input  logic [ERR_AW-1:0] sec_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [NT-1:0]             vld, wr, aux, clr, pend, mask_q;
    logic [NT-1:0][CID_W-1:0]  cid;
    logic [NT-1:0][ERR_AW-1:0] faddr, rec_addr;
    logic [NT-1:0][REG_DW-1:0] rec_stat;
    logic                      mask_we;
    logic                      unused_wdata;

    // Gather the per-type fault inputs into indexed vectors.
    assign vld   = {sec_vld, xlt_vld, dec_vld};
    assign wr    = {sec_write, xlt_write, dec_write};
    assign aux   = {sec_subtype, 1'b0, 1'b0};
    assign cid   = {sec_client, xlt_client, dec_client};
    assign faddr = {sec_addr, xlt_addr, dec_addr};

    // Decode the one-to-clear and mask writes.
    assign clr          = (reg_wr_en && reg_addr == OFS_PEND) ? reg_wdata[NT-1:0] : '0;
    assign mask_we      = reg_wr_en && reg_addr == OFS_MASK;
    assign unused_wdata = ^reg_wdata[31:NT];

    for (genvar k = 0; k < NT; k++) begin : g_rec
        memerr_slot #(
            .KIND   (err_kind_e'(k)),
            .CID_W  (CID_W),
            .ERR_AW (ERR_AW)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .err_vld  (vld[k]),
            .err_cid  (cid[k]),
            .err_wr   (wr[k]),
            .err_aux  (aux[k]),
            .err_addr (faddr[k]),
            .clr      (clr[k]),
            .pending  (pend[k]),
            .stat_q   (rec_stat[k]),
            .addr_q   (rec_addr[k])
        );
    end

    memerr_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata[NT-1:0]),
        .pend       (pend),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_PEND) reg_rdata = 32'(pend);
        if (reg_addr == OFS_MASK) reg_rdata = 32'(mask_q);
        for (int k = 0; k < NT; k++) begin
            if (reg_addr == rec_base(k))         reg_rdata = rec_stat[k];
            if (reg_addr == rec_base(k) + 8'd4)  reg_rdata = 32'(rec_addr[k]);
        end
    end

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|vld) |=> ((pend & $past(vld)) == $past(vld)));
endmodule

// File: tb/tb_memerr_capture.sv
// Scoreboard bench: driver tasks push expected values, a monitor pops and compares.
module tb_memerr_capture;
    localparam int CID_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_vld = 0, xlt_vld = 0, sec_vld = 0;
    logic dec_write = 0, xlt_write = 0, sec_write = 0, sec_subtype = 0;
    logic [CID_W-1:0] dec_client = '0, xlt_client = '0, sec_client = '0;
    logic [31:0] dec_addr = '0, xlt_addr = '0, sec_addr = '0;
    logic reg_wr_en = 0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    memerr_capture #(.CID_W(CID_W), .ERR_AW(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(dec_vld), .dec_client(dec_client), .dec_write(dec_write), .dec_addr(dec_addr),
        .xlt_vld(xlt_vld), .xlt_client(xlt_client), .xlt_write(xlt_write), .xlt_addr(xlt_addr),
        .sec_vld(sec_vld), .sec_client(sec_client), .sec_write(sec_write),
        .sec_subtype(sec_subtype), .sec_addr(sec_addr),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    // Driver: present an offset and queue the expected register value.
    task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        sb.push_back('{1'b0, a, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1;
        sb.push_back('{1'b1, 8'h00, {31'b0, e}, tag});
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 0; reg_wdata = '0;
    endtask

    task automatic fault(input int k, input logic [CID_W-1:0] c, input logic w,
                         input logic s, input logic [31:0] a);
        @(posedge clk); #1;
        case (k)
            0: begin dec_vld = 1; dec_client = c; dec_write = w; dec_addr = a; end
            1: begin xlt_vld = 1; xlt_client = c; xlt_write = w; xlt_addr = a; end
            default: begin sec_vld = 1; sec_client = c; sec_write = w;
                           sec_subtype = s; sec_addr = a; end
        endcase
        @(posedge clk); #1;
        dec_vld = 0; xlt_vld = 0; sec_vld = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state
        chk_reg(8'h00, 32'h0, "R10 pending");
        chk_reg(8'h04, 32'h0, "R10 mask");
        chk_reg(8'h10, 32'h0, "R10 dec status");
        chk_reg(8'h24, 32'h0, "R10 sec addr");
        chk_irq(1'b0, "R10 irq");

        // R9 mask readback
        wr_reg(8'h04, 32'h7);
        chk_reg(8'h04, 32'h7, "R9 mask");

        // R1 decode capture, R4 address, R5 bit 0, R9 irq
        fault(0, 6'd5, 1'b1, 1'b0, 32'hDEAD_0010);
        chk_reg(8'h10, 32'h8000_0005, "R1 dec status");
        chk_reg(8'h14, 32'hDEAD_0010, "R4 dec addr");
        chk_reg(8'h00, 32'h1, "R5 pending dec");
        chk_irq(1'b1, "R9 irq raised");

        // R7 second decode fault while pending is ignored
        fault(0, 6'd9, 1'b0, 1'b0, 32'h0BAD_0020);
        chk_reg(8'h10, 32'h8000_0005, "R7 dec status held");
        chk_reg(8'h14, 32'hDEAD_0010, "R7 dec addr held");

        // R2 translation layout, R5 two bits pending
        fault(1, 6'h2A, 1'b1, 1'b0, 32'h1234_5678);
        chk_reg(8'h18, 32'h0000_0055, "R2 xlt status");
        chk_reg(8'h1C, 32'h1234_5678, "R4 xlt addr");
        chk_reg(8'h00, 32'h3, "R5 two pending");

        // R6 writing zeros clears nothing, writing a one clears only that bit
        wr_reg(8'h00, 32'h0);
        chk_reg(8'h00, 32'h3, "R6 zero write");
        wr_reg(8'h00, 32'h1);
        chk_reg(8'h00, 32'h2, "R6 clear bit0");

        // R8 fault and clear in the same cycle
        fault(0, 6'd7, 1'b1, 1'b0, 32'hAAAA_0004);
        chk_reg(8'h14, 32'hAAAA_0004, "R4 dec re-capture");
        @(posedge clk); #1;
        dec_vld = 1; dec_client = 6'd3; dec_write = 0; dec_addr = 32'h5555_0008;
        reg_wr_en = 1; reg_addr = 8'h00; reg_wdata = 32'h1;
        @(posedge clk); #1;
        dec_vld = 0; reg_wr_en = 0; reg_wdata = '0;
        chk_reg(8'h00, 32'h3, "R8 bit stays set");
        chk_reg(8'h10, 32'h0000_0003, "R8 new status");
        chk_reg(8'h14, 32'h5555_0008, "R8 new addr");

        // R11 masking
        wr_reg(8'h04, 32'h0);
        chk_irq(1'b0, "R11 all masked");
        wr_reg(8'h04, 32'h4);
        chk_irq(1'b0, "R11 only sec enabled");

        // R3 security layout, subtype set, read access
        fault(2, 6'h11, 1'b0, 1'b1, 32'hCAFE_F00C);
        chk_reg(8'h20, 32'h4000_0011, "R3 sec status");
        chk_reg(8'h24, 32'hCAFE_F00C, "R4 sec addr");
        chk_irq(1'b1, "R9 sec irq");

        // R6 and R11: clear all, irq drops
        wr_reg(8'h00, 32'h7);
        chk_reg(8'h00, 32'h0, "R6 all cleared");
        chk_irq(1'b0, "R11 irq dropped");

        // R3 write flag, subtype clear
        fault(2, 6'd2, 1'b1, 1'b0, 32'h0000_0100);
        chk_reg(8'h20, 32'h8000_0002, "R3 sec write");

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule